// File: doc/BRIEF.md
# Requester-Side Transaction Conflict Resolver

This block sits beside a core's coherence request path while a hardware transaction runs. When a request the core has issued comes back refused, the block chooses one of two actions. By default the core stalls for a programmable number of cycles and then reissues the request. It aborts only when two conditions hold: a wait cycle between two cores may have formed, and this core's transaction is the younger of the two. The caller then runs the software undo handler and reports when it is done.

Each transaction's age is the timestamp sampled when its outermost begin arrives. That value holds through nested begins and through every retry. A refusal response carries the responder's timestamp. The block keeps a cycle-risk flag. It sets this flag when the core itself refuses a forwarded request whose timestamp is older than its own, and it clears the flag when the transaction ends. Smaller timestamp values are older.

Top module: `txn_conflict_arbiter`

## Requirements
- R1: After reset, in_tx, cycle_risk, stalled, retry_req and abort_req are all 0.
- R2: An outermost begin (tx_begin while in_tx is 0) latches now_ts into my_ts and sets in_tx one cycle later. A begin while in_tx is 1 leaves my_ts unchanged, and my_ts holds across stalls and retries.
- R3: While in_tx is 1, a local refusal (fwd_nack) sets cycle_risk on the next cycle when fwd_ts < my_ts. A refusal with fwd_ts >= my_ts leaves cycle_risk unchanged.
- R4: tx_commit or tx_abort_done clears in_tx, cycle_risk, abort_req and any stall on the next cycle, and no retry pulse follows. This takes priority over a refusal or a resp_nack in the same cycle.
- R5: A resp_nack that is accepted with no abort condition raises stalled on the next cycle. If the nack is sampled at clock edge k, retry_req is a one-cycle pulse after edge k+retry_delay+1, and stalled drops in that same cycle.
- R6: An accepted resp_nack with the cycle risk present and resp_ts < my_ts raises abort_req on the next cycle, with no stall and no retry. abort_req holds until the transaction ends.
- R7: When the cycle risk is present but resp_ts >= my_ts (equal timestamps count as not older), the requester waits and retries as in R5.
- R8: A local refusal that sets the cycle risk in the same cycle as an accepted resp_nack counts toward that nack's decision.
- R9: resp_nack is ignored while in_tx is 0, while stalled, or while abort_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Transaction begin (may be nested) |
| tx_commit | input | 1 | Transaction committed |
| tx_abort_done | input | 1 | Software abort handler finished |
| now_ts | input | TS_W | Current timestamp source |
| fwd_nack | input | 1 | This core refuses a forwarded request |
| fwd_ts | input | TS_W | Timestamp of the refused forwarded request |
| resp_nack | input | 1 | Own request was refused |
| resp_ts | input | TS_W | Responder timestamp carried by the refusal |
| retry_delay | input | CNT_W | Stall length before reissue |
| in_tx | output | 1 | Transaction active |
| my_ts | output | TS_W | Latched transaction timestamp |
| cycle_risk | output | 1 | A wait cycle may exist |
| stalled | output | 1 | Waiting before a retry |
| retry_req | output | 1 | One-cycle reissue request |
| abort_req | output | 1 | Abort demanded, held until the end |

## Verification
Two events can reach the decision in the same cycle: a local refusal that creates the cycle risk, and the arrival of a refusal for this core's own request. The bench drives fwd_nack with an older fwd_ts and resp_nack with an older resp_ts in a single cycle. It expects an abort on the very next cycle rather than a stall (R8). The second such pairing puts a transaction end in the same cycle as a refusal. There the end must win, so cycle_risk reads 0 afterwards.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int TS_MAX = 64;

  // Strictly older: smaller timestamp value, ties are not older.
  function automatic logic ts_older(logic [TS_MAX-1:0] a, logic [TS_MAX-1:0] b);
    return a < b;
  endfunction

  // Abort only when a cycle may exist and the responder is older than us.
  function automatic logic must_abort(logic risk, logic responder_older);
    return risk & responder_older;
  endfunction
endpackage

// File: rtl/txc_age_track.sv
module txc_age_track
  import txc_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_begin,
  input  logic            tx_end,
  input  logic [TS_W-1:0] now_ts,
  input  logic            fwd_nack,
  input  logic [TS_W-1:0] fwd_ts,
  output logic            in_tx,
  output logic [TS_W-1:0] my_ts,
  output logic            risk_q,
  output logic            risk_now
);
  logic outer_begin;
  logic risk_set;

  assign outer_begin = tx_begin & ~in_tx & ~tx_end;
  assign risk_set    = in_tx & fwd_nack & ~tx_end &
                       ts_older(TS_MAX'(fwd_ts), TS_MAX'(my_ts));
  assign risk_now    = risk_q | risk_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tx  <= 1'b0;
      my_ts  <= '0;
      risk_q <= 1'b0;
    end else if (tx_end) begin
      in_tx  <= 1'b0;
      risk_q <= 1'b0;
    end else begin
      if (outer_begin) begin
        in_tx <= 1'b1;
        my_ts <= now_ts;
      end
      if (risk_set) risk_q <= 1'b1;
    end
  end

  AST_BEGIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    outer_begin |=> (in_tx && my_ts == $past(now_ts))); // R2
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tx && !tx_end) |=> $stable(my_ts)); // R2
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> (!in_tx && !risk_q)); // R4
  AST_RISK_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    risk_q |-> in_tx); // R3
endmodule

// File: rtl/txc_retry_timer.sv
module txc_retry_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [CNT_W-1:0] delay,
  output logic             busy,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             expire;

  assign expire = busy & (cnt == '0) & ~cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= expire;
      if (cancel) begin
        busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= delay;
      end else if (expire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_FIRE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(busy)); // R5
  AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!fire && !busy)); // R4
endmodule

// File: rtl/txn_conflict_arbiter.sv
module txn_conflict_arbiter
  import txc_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin,
  input  logic             tx_commit,
  input  logic             tx_abort_done,
  input  logic [TS_W-1:0]  now_ts,
  input  logic             fwd_nack,
  input  logic [TS_W-1:0]  fwd_ts,
  input  logic             resp_nack,
  input  logic [TS_W-1:0]  resp_ts,
  input  logic [CNT_W-1:0] retry_delay,
  output logic             in_tx,
  output logic [TS_W-1:0]  my_ts,
  output logic             cycle_risk,
  output logic             stalled,
  output logic             retry_req,
  output logic             abort_req
);
  logic tx_end;
  logic risk_now;
  logic nack_take;
  logic resp_older;
  logic go_abort;
  logic go_wait;
  logic abort_q;

  assign tx_end = tx_commit | tx_abort_done;

  txc_age_track #(.TS_W(TS_W)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_begin (tx_begin),
    .tx_end   (tx_end),
    .now_ts   (now_ts),
    .fwd_nack (fwd_nack),
    .fwd_ts   (fwd_ts),
    .in_tx    (in_tx),
    .my_ts    (my_ts),
    .risk_q   (cycle_risk),
    .risk_now (risk_now)
  );

  // Decision events, named for the assertions.
  assign nack_take  = resp_nack & in_tx & ~stalled & ~abort_q & ~tx_end;
  assign resp_older = ts_older(TS_MAX'(resp_ts), TS_MAX'(my_ts));
  assign go_abort   = nack_take & must_abort(risk_now, resp_older);
  assign go_wait    = nack_take & ~go_abort;

  txc_retry_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go_wait),
    .cancel (tx_end),
    .delay  (retry_delay),
    .busy   (stalled),
    .fire   (retry_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        abort_q <= 1'b0;
    else if (tx_end)   abort_q <= 1'b0;
    else if (go_abort) abort_q <= 1'b1;
  end

  assign abort_req = abort_q;

  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    go_wait |=> stalled); // R5
  AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req); // R5
  AST_ABORT_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_req && stalled)); // R6
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !tx_end) |=> abort_req); // R6
  AST_ABORT_RISKY: assert property (@(posedge clk) disable iff (!rst_n)
    go_abort |=> cycle_risk); // R8
  AST_IDLE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_nack && !in_tx) |=> ($stable(abort_req) && !$rose(stalled))); // R9
endmodule

// File: tb/txn_conflict_arbiter_bench.sv
module txn_conflict_arbiter_bench;
  localparam int TS_W  = 16;
  localparam int CNT_W = 8;
  localparam int K_RETRY = 0;
  localparam int K_ABORT = 1;

  typedef struct {
    int    cyc;
    int    kind;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0, tx_abort_done = 0;
  logic fwd_nack = 0, resp_nack = 0;
  logic [TS_W-1:0]  now_ts = '0, fwd_ts = '0, resp_ts = '0;
  logic [CNT_W-1:0] retry_delay = '0;
  logic in_tx, cycle_risk, stalled, retry_req, abort_req;
  logic [TS_W-1:0] my_ts;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];
  logic abort_prev = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txn_conflict_arbiter #(.TS_W(TS_W), .CNT_W(CNT_W)) u_txn_conflict_arbiter (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort_done(tx_abort_done), .now_ts(now_ts), .fwd_nack(fwd_nack),
    .fwd_ts(fwd_ts), .resp_nack(resp_nack), .resp_ts(resp_ts),
    .retry_delay(retry_delay), .in_tx(in_tx), .my_ts(my_ts),
    .cycle_risk(cycle_risk), .stalled(stalled), .retry_req(retry_req),
    .abort_req(abort_req)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: retry pulses and abort rises are popped from the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (retry_req || (abort_req && !abort_prev)) begin
        int kind;
        kind = retry_req ? K_RETRY : K_ABORT;
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected event", kind, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.kind == kind, e.req, kind, e.kind);
          check(e.cyc == cyc, e.req, cyc, e.cyc);
        end
      end
      abort_prev = abort_req;
    end
  end

  // Driver: one refusal of our request; the expectation is pushed by the caller.
  task automatic nack(input int ts, input int dly, input int kind, input string req);
    exp_t e;
    resp_nack = 1; resp_ts = TS_W'(ts); retry_delay = CNT_W'(dly);
    if (kind == K_RETRY) e = '{cyc + dly + 2, K_RETRY, req};
    else if (kind == K_ABORT) e = '{cyc + 1, K_ABORT, req};
    if (kind >= 0) sb.push_back(e);
    step();
    resp_nack = 0;
  endtask

  task automatic begin_tx(input int ts);
    tx_begin = 1; now_ts = TS_W'(ts);
    step();
    tx_begin = 0;
  endtask

  task automatic refuse(input int ts);
    fwd_nack = 1; fwd_ts = TS_W'(ts);
    step();
    fwd_nack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    check(!in_tx && !cycle_risk && !stalled && !retry_req && !abort_req, "R1 reset",
          {in_tx, cycle_risk, stalled, retry_req, abort_req}, 0);

    // R2 outermost begin and nested begin
    begin_tx(100);
    check(in_tx && my_ts == 100, "R2 capture", my_ts, 100);
    begin_tx(200);
    check(my_ts == 100, "R2 nested keeps ts", my_ts, 100);

    // R5 plain wait and retry, R9 nack during stall ignored
    nack(50, 3, K_RETRY, "R5 retry timing");
    check(stalled, "R5 stalled", stalled, 1);
    nack(50, 0, -1, "R9");
    step(6);
    check(!stalled && my_ts == 100, "R2 ts across retry", my_ts, 100);

    // R3 younger refusal does not set risk, older does
    refuse(150);
    check(!cycle_risk, "R3 younger refused", cycle_risk, 0);
    refuse(40);
    check(cycle_risk, "R3 older refused", cycle_risk, 1);

    // R7 risk present but we are older or equal: wait
    nack(120, 1, K_RETRY, "R7 responder younger");
    step(4);
    nack(100, 2, K_RETRY, "R7 equal ts");
    step(5);

    // R6 abort when younger
    nack(90, 4, K_ABORT, "R6 abort");
    check(abort_req && !stalled, "R6 no stall", stalled, 0);
    nack(10, 0, -1, "R9");
    step(3);
    check(abort_req, "R6 abort held", abort_req, 1);
    tx_abort_done = 1; step(); tx_abort_done = 0;
    check(!abort_req && !in_tx && !cycle_risk, "R4 abort done clears",
          {abort_req, in_tx, cycle_risk}, 0);

    // R9 nack outside a transaction
    nack(1, 0, -1, "R9");
    step(4);
    check(!stalled && !abort_req, "R9 idle nack", {stalled, abort_req}, 0);

    // R8 refusal and nack in the same cycle
    begin_tx(300);
    fwd_nack = 1; fwd_ts = 10;
    nack(20, 2, K_ABORT, "R8 same-cycle risk");
    fwd_nack = 0;
    check(abort_req && cycle_risk, "R8 abort", abort_req, 1);
    tx_commit = 1; step(); tx_commit = 0;
    check(!abort_req && !in_tx, "R4 commit clears", {abort_req, in_tx}, 0);

    // R4 end wins over a same-cycle refusal
    begin_tx(500);
    fwd_nack = 1; fwd_ts = 5; tx_commit = 1;
    step();
    fwd_nack = 0; tx_commit = 0;
    check(!cycle_risk && !in_tx, "R4 end beats refusal", cycle_risk, 0);

    // R4 commit during stall cancels the retry
    begin_tx(600);
    nack(1, 5, -1, "R4");
    check(stalled, "R5 stalled long", stalled, 1);
    tx_commit = 1; step(); tx_commit = 0;
    check(!stalled, "R4 stall cancelled", stalled, 0);
    step(8);

    // R5 zero delay retry
    begin_tx(700);
    nack(1, 0, K_RETRY, "R5 zero delay");
    step(4);

    check(sb.size() == 0, "R5 all events seen", sb.size(), 0);
    finish_run();
  end
endmodule